// File: doc/BRIEF.md
# UART Receiver with Error Flags

This block turns an asynchronous serial line into characters. The line is first brought into the clock domain by a two-stage synchronizer. It is then sampled on a 16x oversampling enable that a separate baud generator supplies. A falling edge on the line, followed by a low sample half a bit later, starts a frame. Each further bit is sampled at its centre. The configuration pins select 7, 8 or 9 data bits, parity off, even or odd, and one or two stop bits.

When the last stop bit has been sampled, the character moves from the shift register into a 9-bit holding register. Parity, stop-bit and overrun checks are evaluated and latched only at that transfer. The held character leaves the block on a valid/ready pair. `rx_valid` is the receive-complete flag, and a cycle with `rx_valid && rx_ready` is the read of the low byte. The serial line cannot be stalled, so there is no back-pressure. If the consumer has not taken a character when the next one completes, the new character replaces the old one and the overrun flag is set. `rx_ready` has no effect while `rx_valid` is low.

A receive interrupt request rises on each transfer and stays up until `irq_ack`. A clean overrun leaves the request unchanged. Dropping `rx_en` returns the receiver to idle and clears the holding register and every flag.

Top module: `serial_rx_flags`

## Requirements
- R1: A frame is one low start bit, then the data bits LSB first, then an optional parity bit, then the stop bits. `len_sel` selects the data length: 0 gives 7 bits, 1 gives 8, 2 gives 9 and 3 gives 8. `stop2`=1 selects two stop bits. The character appears right-aligned in `rx_data[8:0]`, with unused high bits at 0.
- R2: A start bit is accepted only if the line is still low 8 sample ticks after the falling edge. A shorter low pulse produces no character.
- R3: With `par_en`=1, `par_err` is set when the number of 1s in the data and parity bits is odd and `par_odd`=0, or even and `par_odd`=1. With `par_en`=0, no parity bit is expected and `par_err` stays 0.
- R4: `frm_err` is set when any configured stop bit is sampled low.
- R5: The error flags change only in the cycle a character is loaded into the buffer. In that cycle `rx_valid` rises or stays high and `irq` is set.
- R6: If a character is loaded while `rx_valid` is still 1 and is not being read in that cycle, `ovr_err` is set and `rx_data` takes the new character. If that character has no parity or framing error, `irq` keeps its previous value.
- R7: `err_sum` is 1 exactly when at least one of `ovr_err`, `frm_err` and `par_err` is 1.
- R8: A cycle with `rx_valid && rx_ready` and no new load clears `rx_valid`, `ovr_err`, `frm_err`, `par_err` and `err_sum` on the next edge. `rx_ready` has no effect while `rx_valid` is 0.
- R9: While `rx_en` is 0, `rx_data`, `rx_valid` and all error flags are 0 and the line is ignored. After `rx_en` returns to 1, the next frame is received from a fresh state.
- R10: `irq` stays 1 until an `irq_ack` cycle clears it. A load in the same cycle as `irq_ack` wins.
- R11: A synchronous reset (`rst`=1) clears every output to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| sample_tick | input | 1 | 16x oversampling enable |
| rx_in | input | 1 | Serial line, idles high |
| rx_en | input | 1 | Receive enable; 0 idles the receiver and clears state |
| len_sel | input | 2 | Data length select (0:7, 1:8, 2:9, 3:8 bits) |
| par_en | input | 1 | Parity bit present |
| par_odd | input | 1 | 1 selects odd parity, 0 selects even |
| stop2 | input | 1 | 1 selects two stop bits |
| rx_ready | input | 1 | Consumer takes the held character (low-byte read) |
| irq_ack | input | 1 | Clears the interrupt request |
| rx_data | output | 9 | Held character |
| rx_valid | output | 1 | Receive-complete flag |
| ovr_err | output | 1 | Overrun flag |
| frm_err | output | 1 | Framing error flag |
| par_err | output | 1 | Parity error flag |
| err_sum | output | 1 | OR of the three error flags |
| irq | output | 1 | Receive interrupt request |

## Verification
Assertions check on every cycle that the error summary matches the three flags and that parity errors appear only together with a held character. They also check that a read or a disabled receiver clears the flags, that the interrupt request holds until acknowledged, that a clean overrun leaves it alone, and that a failed start check returns the receiver to idle. Only the bench scenarios can show that bits are taken at the right positions for each length, parity sense and stop count. The same holds for computing parity and stop errors from real line waveforms, rejecting a short start glitch and replacing the held character on overrun.

// File: rtl/serial_rx_pkg.sv
package serial_rx_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PAR,
    ST_STOP1,
    ST_STOP2
  } fr_state_t;

  // data length code -> number of data bits
  function automatic logic [3:0] data_bits(input logic [1:0] code);
    case (code)
      2'd0:    data_bits = 4'd7;
      2'd2:    data_bits = 4'd9;
      default: data_bits = 4'd8;
    endcase
  endfunction

endpackage

// File: rtl/serial_rx_framer.sv
module serial_rx_framer
  import serial_rx_pkg::*;
#(
  parameter int OSR = 16,
  parameter int DW  = 9
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          rx_en,
  input  logic          sample_tick,
  input  logic          rx_in,
  input  logic [1:0]    len_sel,
  input  logic          par_en,
  input  logic          par_odd,
  input  logic          stop2,
  output logic          done,
  output logic [DW-1:0] word,
  output logic          par_bad,
  output logic          frm_bad
);
  localparam int CW   = $clog2(OSR);
  localparam int HALF = OSR / 2;
  localparam int IW   = $clog2(DW + 1);

  logic [1:0]    sync_q;
  logic          line;
  fr_state_t     st;
  logic [CW-1:0] cnt;
  logic [IW-1:0] idx;
  logic [IW-1:0] nbits;
  logic          prev_line;
  logic          acc;

  assign line  = sync_q[1];
  assign nbits = IW'(data_bits(len_sel));

  always_ff @(posedge clk) begin
    if (rst) sync_q <= 2'b11;
    else     sync_q <= {sync_q[0], rx_in};
  end

  always_ff @(posedge clk) begin
    if (rst || !rx_en) begin
      st        <= ST_IDLE;
      cnt       <= '0;
      idx       <= '0;
      prev_line <= 1'b1;
      acc       <= 1'b0;
      word      <= '0;
      par_bad   <= 1'b0;
      frm_bad   <= 1'b0;
      done      <= 1'b0;
    end else begin
      done <= 1'b0;
      if (sample_tick) begin
        prev_line <= line;
        case (st)
          ST_IDLE: begin
            if (prev_line && !line) begin
              st  <= ST_START;
              cnt <= '0;
            end
          end
          ST_START: begin
            if (cnt == CW'(HALF - 1)) begin
              cnt <= '0;
              if (!line) begin
                st      <= ST_DATA;
                idx     <= '0;
                acc     <= 1'b0;
                word    <= '0;
                par_bad <= 1'b0;
                frm_bad <= 1'b0;
              end else begin
                st <= ST_IDLE;
              end
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          default: begin
            if (cnt == CW'(OSR - 1)) begin
              cnt <= '0;
              case (st)
                ST_DATA: begin
                  word <= word | (DW'(line) << idx);
                  acc  <= acc ^ line;
                  if (idx == nbits - IW'(1)) st <= par_en ? ST_PAR : ST_STOP1;
                  else                       idx <= idx + 1'b1;
                end
                ST_PAR: begin
                  par_bad <= ((acc ^ line) != par_odd);
                  st      <= ST_STOP1;
                end
                ST_STOP1: begin
                  frm_bad <= !line;
                  if (stop2) begin
                    st <= ST_STOP2;
                  end else begin
                    st   <= ST_IDLE;
                    done <= 1'b1;
                  end
                end
                default: begin
                  frm_bad <= frm_bad | !line;
                  st      <= ST_IDLE;
                  done    <= 1'b1;
                end
              endcase
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
        endcase
      end
    end
  end

  // R2: a start bit found high at mid-bit is dropped
  a_r2_false_start_idle: assert property (@(posedge clk) disable iff (rst)
    (rx_en && sample_tick && st == ST_START && cnt == CW'(HALF - 1) && line)
      |=> (st == ST_IDLE && !done));

  // R1: a completed frame leaves the framer idle
  a_r1_done_idle: assert property (@(posedge clk) disable iff (rst)
    done |-> (st == ST_IDLE));

endmodule

// File: rtl/serial_rx_holding.sv
module serial_rx_holding #(
  parameter int DW = 9
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          rx_en,
  input  logic          load,
  input  logic [DW-1:0] new_word,
  input  logic          new_par,
  input  logic          new_frm,
  input  logic          rx_ready,
  input  logic          irq_ack,
  output logic [DW-1:0] rx_data,
  output logic          rx_valid,
  output logic          ovr_err,
  output logic          frm_err,
  output logic          par_err,
  output logic          err_sum,
  output logic          irq
);
  logic rd;
  logic ovr_now;
  logic ovr_n, frm_n, par_n;

  assign rd      = rx_valid && rx_ready;
  assign ovr_now = rx_valid && !rd;
  assign ovr_n   = (ovr_err && !rd) || ovr_now;
  assign frm_n   = (frm_err && !rd) || new_frm;
  assign par_n   = (par_err && !rd) || new_par;

  always_ff @(posedge clk) begin
    if (rst || !rx_en) begin
      rx_data  <= '0;
      rx_valid <= 1'b0;
      ovr_err  <= 1'b0;
      frm_err  <= 1'b0;
      par_err  <= 1'b0;
      err_sum  <= 1'b0;
    end else if (load) begin
      rx_data  <= new_word;
      rx_valid <= 1'b1;
      ovr_err  <= ovr_n;
      frm_err  <= frm_n;
      par_err  <= par_n;
      err_sum  <= ovr_n || frm_n || par_n;
    end else if (rd) begin
      rx_valid <= 1'b0;
      ovr_err  <= 1'b0;
      frm_err  <= 1'b0;
      par_err  <= 1'b0;
      err_sum  <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)                                                irq <= 1'b0;
    else if (rx_en && load && (!ovr_now || new_frm || new_par)) irq <= 1'b1;
    else if (irq_ack)                                       irq <= 1'b0;
  end

  // R7
  a_r7_sum_matches: assert property (@(posedge clk) disable iff (rst)
    err_sum == (ovr_err || frm_err || par_err));

  // R5
  a_r5_par_with_valid: assert property (@(posedge clk) disable iff (rst)
    $rose(par_err) |-> rx_valid);

  // R6
  a_r6_ovr_keeps_irq: assert property (@(posedge clk) disable iff (rst)
    (rx_en && load && ovr_now && !new_frm && !new_par && !irq && !irq_ack) |=> !irq);

  // R8
  a_r8_read_clears: assert property (@(posedge clk) disable iff (rst)
    (rx_valid && rx_ready && !load) |=> (!rx_valid && !err_sum && !ovr_err));

  // R9
  a_r9_disable_clears: assert property (@(posedge clk) disable iff (rst)
    !rx_en |=> (!rx_valid && rx_data == '0 && !err_sum));

  // R10
  a_r10_irq_holds: assert property (@(posedge clk) disable iff (rst)
    (irq && !irq_ack) |=> irq);

endmodule

// File: rtl/serial_rx_flags.sv
module serial_rx_flags #(
  parameter int OSR = 16,
  parameter int DW  = 9
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          sample_tick,
  input  logic          rx_in,
  input  logic          rx_en,
  input  logic [1:0]    len_sel,
  input  logic          par_en,
  input  logic          par_odd,
  input  logic          stop2,
  input  logic          rx_ready,
  input  logic          irq_ack,
  output logic [DW-1:0] rx_data,
  output logic          rx_valid,
  output logic          ovr_err,
  output logic          frm_err,
  output logic          par_err,
  output logic          err_sum,
  output logic          irq
);
  logic          done;
  logic [DW-1:0] word;
  logic          par_bad;
  logic          frm_bad;

  serial_rx_framer #(.OSR(OSR), .DW(DW)) framer_i (
    .clk         (clk),
    .rst         (rst),
    .rx_en       (rx_en),
    .sample_tick (sample_tick),
    .rx_in       (rx_in),
    .len_sel     (len_sel),
    .par_en      (par_en),
    .par_odd     (par_odd),
    .stop2       (stop2),
    .done        (done),
    .word        (word),
    .par_bad     (par_bad),
    .frm_bad     (frm_bad)
  );

  serial_rx_holding #(.DW(DW)) holding_i (
    .clk      (clk),
    .rst      (rst),
    .rx_en    (rx_en),
    .load     (done),
    .new_word (word),
    .new_par  (par_bad),
    .new_frm  (frm_bad),
    .rx_ready (rx_ready),
    .irq_ack  (irq_ack),
    .rx_data  (rx_data),
    .rx_valid (rx_valid),
    .ovr_err  (ovr_err),
    .frm_err  (frm_err),
    .par_err  (par_err),
    .err_sum  (err_sum),
    .irq      (irq)
  );

endmodule

// File: tb/serial_rx_flags_tb_top.sv
module serial_rx_flags_tb_top;
  localparam int TICK_DIV = 4;
  localparam int BIT_CLKS = 16 * TICK_DIV;
  localparam int NVEC     = 11;

  // {len_sel[15:14], par_en, par_odd, stop2, bad_par, bad_stop, data[8:0]}
  localparam logic [15:0] VEC [NVEC] = '{
    {2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 9'h055},
    {2'd1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 9'h0A5},
    {2'd2, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 9'h1C3},
    {2'd1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 9'h037},
    {2'd1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 9'h037},
    {2'd1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 9'h080},
    {2'd0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 9'h07E},
    {2'd2, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 9'h101},
    {2'd1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 9'h03C},
    {2'd1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 9'h0FF},
    {2'd3, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 9'h1F0}
  };

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       sample_tick;
  logic       rx_in = 1'b1;
  logic       rx_en = 1'b1;
  logic [1:0] len_sel = 2'd1;
  logic       par_en = 1'b0;
  logic       par_odd = 1'b0;
  logic       stop2 = 1'b0;
  logic       rx_ready = 1'b0;
  logic       irq_ack = 1'b0;
  logic [8:0] rx_data;
  logic       rx_valid, ovr_err, frm_err, par_err, err_sum, irq;

  int checks = 0;
  int failures = 0;
  logic [1:0] tick_cnt = '0;

  always #10 clk = ~clk;

  always_ff @(posedge clk) tick_cnt <= tick_cnt + 1'b1;
  assign sample_tick = (tick_cnt == 2'd3);

  serial_rx_flags dut_i (
    .clk(clk), .rst(rst), .sample_tick(sample_tick), .rx_in(rx_in),
    .rx_en(rx_en), .len_sel(len_sel), .par_en(par_en), .par_odd(par_odd),
    .stop2(stop2), .rx_ready(rx_ready), .irq_ack(irq_ack),
    .rx_data(rx_data), .rx_valid(rx_valid), .ovr_err(ovr_err),
    .frm_err(frm_err), .par_err(par_err), .err_sum(err_sum), .irq(irq)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic line_bit(input logic v);
    @(posedge clk);
    #1 rx_in = v;
    repeat (BIT_CLKS - 1) @(posedge clk);
  endtask

  function automatic int nbits_of(input logic [1:0] ln);
    return (ln == 2'd0) ? 7 : (ln == 2'd2) ? 9 : 8;
  endfunction

  task automatic send_frame(input logic [1:0] ln, input logic pe, input logic po,
                            input logic s2, input logic [8:0] d,
                            input logic bp, input logic bs);
    int n;
    logic [8:0] m;
    n = nbits_of(ln);
    m = 9'((10'h1 << n) - 1);
    len_sel = ln; par_en = pe; par_odd = po; stop2 = s2;
    line_bit(1'b0);
    for (int i = 0; i < n; i++) line_bit(d[i]);
    if (pe) line_bit((^(d & m)) ^ po ^ bp);
    if (s2) line_bit(1'b1);
    line_bit(!bs);
    line_bit(1'b1);
    line_bit(1'b1);
  endtask

  task automatic pulse_ready();
    @(posedge clk); #1 rx_ready = 1'b1;
    @(posedge clk); #1 rx_ready = 1'b0;
    @(posedge clk); #1;
  endtask

  task automatic pulse_ack();
    @(posedge clk); #1 irq_ack = 1'b1;
    @(posedge clk); #1 irq_ack = 1'b0;
    @(posedge clk); #1;
  endtask

  initial begin
    logic [15:0] v;
    logic [8:0]  m;
    logic        ep, ef;

    repeat (4) @(posedge clk);
    #1;
    // R11: reset state
    check("R11 valid", 16'(rx_valid), 16'h0);
    check("R11 data", 16'(rx_data), 16'h0);
    check("R11 flags", 16'({ovr_err, frm_err, par_err, err_sum, irq}), 16'h0);
    rst = 1'b0;
    repeat (BIT_CLKS) @(posedge clk);

    // vector table: R1 R3 R4 R5 R7 R8 R10
    for (int k = 0; k < NVEC; k++) begin
      v = VEC[k];
      send_frame(v[15:14], v[13], v[12], v[11], v[8:0], v[10], v[9]);
      m  = 9'((10'h1 << nbits_of(v[15:14])) - 1);
      ep = v[13] & v[10];
      ef = v[9];
      check("R1 data", 16'(rx_data), 16'(v[8:0] & m));
      check("R5 valid", 16'(rx_valid), 16'h1);
      check("R3 par_err", 16'(par_err), 16'(ep));
      check("R4 frm_err", 16'(frm_err), 16'(ef));
      check("R7 err_sum", 16'(err_sum), 16'(ep | ef));
      check("R5 irq", 16'(irq), 16'h1);
      check("R6 no overrun", 16'(ovr_err), 16'h0);
      pulse_ready();
      check("R8 valid cleared", 16'(rx_valid), 16'h0);
      check("R8 flags cleared", 16'({ovr_err, frm_err, par_err, err_sum}), 16'h0);
      check("R10 irq held after read", 16'(irq), 16'h1);
      pulse_ack();
      check("R10 irq cleared by ack", 16'(irq), 16'h0);
    end

    // R8: ready with nothing held changes nothing
    pulse_ready();
    check("R8 idle ready", 16'({rx_valid, err_sum, irq}), 16'h0);

    // R6: overrun replaces data, irq unchanged
    send_frame(2'd1, 1'b0, 1'b0, 1'b0, 9'h011, 1'b0, 1'b0);
    pulse_ack();
    send_frame(2'd1, 1'b0, 1'b0, 1'b0, 9'h022, 1'b0, 1'b0);
    check("R6 data replaced", 16'(rx_data), 16'h022);
    check("R6 ovr_err", 16'(ovr_err), 16'h1);
    check("R7 sum on overrun", 16'(err_sum), 16'h1);
    check("R6 irq unchanged", 16'(irq), 16'h0);
    check("R6 still valid", 16'(rx_valid), 16'h1);
    pulse_ready();
    check("R8 ovr cleared", 16'({ovr_err, err_sum, rx_valid}), 16'h0);

    // R2: short low glitch is not a start
    @(posedge clk); #1 rx_in = 1'b0;
    repeat (4 * TICK_DIV) @(posedge clk);
    #1 rx_in = 1'b1;
    repeat (BIT_CLKS * 12) @(posedge clk);
    #1;
    check("R2 glitch ignored", 16'(rx_valid), 16'h0);
    send_frame(2'd1, 1'b0, 1'b0, 1'b0, 9'h05A, 1'b0, 1'b0);
    check("R2 frame after glitch", 16'(rx_data), 16'h05A);
    pulse_ready();
    pulse_ack();

    // R9: disable clears, ignores line, restarts fresh
    send_frame(2'd1, 1'b1, 1'b0, 1'b0, 9'h0C3, 1'b1, 1'b0);
    check("R9 pre error", 16'(par_err), 16'h1);
    @(posedge clk); #1 rx_en = 1'b0;
    repeat (2) @(posedge clk);
    #1;
    check("R9 cleared", 16'({rx_valid, ovr_err, frm_err, par_err, err_sum}), 16'h0);
    check("R9 data cleared", 16'(rx_data), 16'h0);
    pulse_ack();
    send_frame(2'd1, 1'b0, 1'b0, 1'b0, 9'h099, 1'b0, 1'b0);
    check("R9 line ignored", 16'({rx_valid, irq}), 16'h0);
    @(posedge clk); #1 rx_en = 1'b1;
    send_frame(2'd1, 1'b0, 1'b0, 1'b0, 9'h066, 1'b0, 1'b0);
    check("R9 fresh data", 16'(rx_data), 16'h066);
    check("R9 fresh flags", 16'({ovr_err, frm_err, par_err, err_sum}), 16'h0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule